// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the internal write sequencer of a byte-wide parallel flash array. A command decoder in front of it hands over a start request: either a byte program (address and data) or a whole-array erase. The block times the operation with its own cycle counter and commits the result to a small behavioural byte array when the count runs out.

While an operation runs, the block reports progress three ways at once. A read of the address being programmed returns bit 7 inverted. Bit 6 of any read flips on each new read strobe. An active-low ready/busy line is held low. A low-protected boot region can be shielded from both program and erase through a lock input. Reads are served from the array through a chip-enable / output-enable strobe pair. A registered output-enable flag stands in for the data bus driver.

Top module: `flash_prog_engine`

## Requirements
- R1: A completed program stores the old byte ANDed with the supplied data, so programming can only clear bits; only an erase sets bits back to 1.
- R2: A completed erase sets every byte to 0xFF, except the boot region (the lowest BOOT_BYTES addresses by default, the highest when BOOT_AT_TOP=1) while the lock input was high at the start of the erase.
- R3: A program to a boot-region address started with the lock input high leaves that byte unchanged.
- R4: During a program, a read of the address being programmed returns the inverse of the loaded data's bit 7 in bit 7. Reads of other addresses, and all reads after completion, return true bit 7.
- R5: During any operation, bit 6 of the read data inverts on each new read strobe (rising edge of ce_i & oe_i & ~we_i), whatever the address. When idle, bit 6 is the stored bit.
- R6: ry_by_no goes low in the cycle after a start is accepted and stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R7: rst_ni low aborts any running operation without changing the array. It releases ry_by_no high and clears oe_flag_o at once.
- R8: A start request that arrives while busy is ignored and produces a one-cycle pulse on reject_o in the following cycle.
- R9: oe_flag_o is high in the cycle after ce_i and oe_i were both high with we_i low, and low otherwise.
- R10: If program and erase are requested in the same cycle, the erase is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset / abort |
| prog_req_i | input | 1 | Start byte program |
| erase_req_i | input | 1 | Start whole-array erase |
| boot_lock_i | input | 1 | Boot region protection, sampled at start |
| addr_i | input | ADDR_W | Program and read address |
| wdata_i | input | 8 | Program data |
| ce_i | input | 1 | Chip enable |
| oe_i | input | 1 | Output enable |
| we_i | input | 1 | Write enable (blocks the read flag) |
| rdata_o | output | 8 | Read data with status bits |
| oe_flag_o | output | 1 | Registered output-driver enable |
| ry_by_no | output | 1 | Ready (high) / busy (low) |
| reject_o | output | 1 | Start dropped while busy |

## Verification
The bench checks the exact busy length for both operation kinds. A timer that is off by one would shorten or stretch the low period on ry_by_no. It polls mid-program: at the loaded address a missing inversion would show true bit 7, and at another address a spurious inversion would show up. Successive strobes during busy must differ in bit 6, while idle reads must not toggle. The bench also covers these cases:
- A start request during busy: a sequencer that accepts it would erase the array after the program.
- A locked erase and a locked program: a wrong boot decode would either wipe the shielded bytes or protect the wrong ones.
- Simultaneous requests: the erase must win.
- A reset in the middle of a program: a commit on abort would leave the target byte changed.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam int unsigned DATA_W = 8;
  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE} op_e;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned PROG_CYC  = 12,
  parameter int unsigned ERASE_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_erase_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] MAX_LD   = CNT_W'(MAX_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= is_erase_i ? ERASE_LD : PROG_LD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= MAX_LD);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_eng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned BOOT_BYTES  = 8,
  parameter bit          BOOT_AT_TOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_prog_i,
  input  logic              wr_erase_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] rd_bank [DEPTH];
  logic              past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam bit IN_BOOT = BOOT_AT_TOP ? (g >= DEPTH - BOOT_BYTES) : (g < BOOT_BYTES);
    logic [DATA_W-1:0] byte_q;
    logic              shielded;
    assign shielded = IN_BOOT && lock_i;

    // contents survive reset; only completed operations touch them
    always_ff @(posedge clk_i) begin
      if (wr_erase_i && !shielded)
        byte_q <= '1;
      else if (wr_prog_i && (waddr_i == ADDR_W'(g)) && !shielded)
        byte_q <= byte_q & wdata_i;
    end
    assign rd_bank[g] = byte_q;

    a_r1_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok_q && !$past(wr_erase_i)) |-> ((byte_q & ~$past(byte_q)) == '0));
  end

  assign rdata_o = rd_bank[raddr_i];
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_eng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned PROG_CYC    = 12,
  parameter int unsigned ERASE_CYC   = 30,
  parameter int unsigned BOOT_BYTES  = 8,
  parameter bit          BOOT_AT_TOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_req_i,
  input  logic              erase_req_i,
  input  logic              boot_lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              ce_i,
  input  logic              oe_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic              oe_flag_o,
  output logic              ry_by_no,
  output logic              reject_o
);
  logic              busy, done, req_any, accept;
  op_e               op_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic              op_lock_q;
  logic              rd_act, rd_act_q, rd_strobe, tgl_q, reject_q, past_ok_q;
  logic [DATA_W-1:0] rd_raw;

  assign req_any = prog_req_i | erase_req_i;
  assign accept  = req_any && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      op_addr_q <= '0;
      op_data_q <= '0;
      op_lock_q <= 1'b0;
      reject_q  <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      reject_q  <= req_any && busy;
      if (accept) begin
        op_q      <= erase_req_i ? OP_ERASE : OP_PROG; // erase wins a tie
        op_addr_q <= addr_i;
        op_data_q <= wdata_i;
        op_lock_q <= boot_lock_i;
      end
    end
  end

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (req_any),
    .is_erase_i (erase_req_i),
    .busy_o     (busy),
    .done_o     (done)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BOOT_AT_TOP(BOOT_AT_TOP)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_prog_i  (done && op_q == OP_PROG),
    .wr_erase_i (done && op_q == OP_ERASE),
    .lock_i     (op_lock_q),
    .waddr_i    (op_addr_q),
    .wdata_i    (op_data_q),
    .raddr_i    (addr_i),
    .rdata_o    (rd_raw)
  );

  // read strobe edge drives the toggle bit
  assign rd_act    = ce_i && oe_i && !we_i;
  assign rd_strobe = rd_act && !rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      tgl_q    <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_strobe && busy) tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    rdata_o = rd_raw;
    if (busy) begin
      rdata_o[6] = tgl_q;
      if (op_q == OP_PROG && addr_i == op_addr_q) rdata_o[7] = ~op_data_q[7];
    end
  end

  assign oe_flag_o = rd_act_q;
  assign ry_by_no  = ~busy;
  assign reject_o  = reject_q;

  a_r8_reject_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && reject_o) |-> $past(!ry_by_no));
  a_r6_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ry_by_no);
  a_r5_idle_no_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && ry_by_no && $past(ry_by_no)) |-> $stable(tgl_q));
  a_r9_flag_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && oe_flag_o) |-> $past(ce_i && oe_i && !we_i));
endmodule

// File: tb/tb_flash_prog_engine.sv
module tb_flash_prog_engine;
  localparam int AW = 6, DEPTH = 64, PCYC = 12, ECYC = 30, BOOT = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic prog_req = 0, erase_req = 0, lock = 0, ce = 0, oe = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic oe_flag, ry_by_n, reject;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  flash_prog_engine #(.ADDR_W(AW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC), .BOOT_BYTES(BOOT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .prog_req_i(prog_req), .erase_req_i(erase_req),
    .boot_lock_i(lock), .addr_i(addr), .wdata_i(wdata), .ce_i(ce), .oe_i(oe), .we_i(we),
    .rdata_o(rdata), .oe_flag_o(oe_flag), .ry_by_no(ry_by_n), .reject_o(reject));

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit in_boot(input int a);
    return a < BOOT;
  endfunction

  task automatic start_op(input bit p, input bit e, input int a, input logic [7:0] d, input bit lk);
    @(negedge clk);
    prog_req = p; erase_req = e; addr = AW'(a); wdata = d; lock = lk;
    @(negedge clk);
    prog_req = 0; erase_req = 0; lock = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ry_by_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    ce = 1; oe = 1; addr = AW'(a);
    #1 v = rdata;
    @(negedge clk);
    ce = 0; oe = 0;
  endtask

  task automatic model_prog(input int a, input logic [7:0] d, input bit lk);
    if (!(lk && in_boot(a))) model[a] = model[a] & d;
  endtask

  task automatic model_erase(input bit lk);
    for (int i = 0; i < DEPTH; i++) if (!(lk && in_boot(i))) model[i] = 8'hFF;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check(v == model[i], req, v, model[i]);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog got=0 exp=1");
    summary();
  end

  initial begin
    int n;
    logic [7:0] v, v2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(ry_by_n == 1 && oe_flag == 0 && reject == 0, "R7 reset state", {ry_by_n, oe_flag, reject}, 3'b100);
    rst_ni = 1;

    // R6 erase length, R2 unlocked erase
    start_op(0, 1, 0, 0, 0);
    wait_ready(n);
    check(n == ECYC, "R6 erase busy length", n, ECYC);
    model_erase(0);
    check_all("R2 erase all ones");

    // R4/R5 polling during a program
    start_op(1, 0, 20, 8'hA5, 0);
    rd(20, v);
    check((v & 8'hBF) == 8'h3F, "R4 inverted bit7 at loaded addr", v & 8'hBF, 8'h3F);
    rd(21, v2);
    check(v2[7] == 1'b1, "R4 true bit7 at other addr", v2[7], 1);
    check(v2[6] != v[6], "R5 bit6 toggles per strobe", v2[6], ~v[6]);
    wait_ready(n);
    model_prog(20, 8'hA5, 0);
    rd(20, v);
    check(v == 8'hA5, "R4 true data after done", v, 8'hA5);
    rd(20, v2);
    check(v2 == v, "R5 idle bit6 stable", v2, v);

    // R6 program length, R1 AND semantics
    start_op(1, 0, 20, 8'h3C, 0);
    wait_ready(n);
    check(n == PCYC, "R6 program busy length", n, PCYC);
    model_prog(20, 8'h3C, 0);
    rd(20, v);
    check(v == 8'h24, "R1 program ANDs", v, 8'h24);

    // R1 random programs
    for (int i = 0; i < 40; i++) begin
      int a;
      logic [7:0] d;
      a = int'($urandom % DEPTH);
      d = 8'($urandom);
      start_op(1, 0, a, d, 0);
      wait_ready(n);
      model_prog(a, d, 0);
    end
    check_all("R1 random program");

    // R8 reject while busy
    start_op(1, 0, 31, 8'h0F, 0);
    wait_ready(n);
    model_prog(31, 8'h0F, 0);
    @(negedge clk);
    prog_req = 1; addr = 30; wdata = 8'h00;
    @(negedge clk);
    prog_req = 0; erase_req = 1;
    @(negedge clk);
    erase_req = 0;
    check(reject == 1, "R8 reject pulse", reject, 1);
    @(negedge clk);
    check(reject == 0, "R8 reject one cycle", reject, 0);
    wait_ready(n);
    model_prog(30, 8'h00, 0);
    rd(30, v);
    check(v == 8'h00, "R8 program kept", v, 0);
    rd(31, v);
    check(v == model[31], "R8 erase ignored", v, model[31]);

    // R2/R3 boot lock
    start_op(1, 0, 2, 8'h5A, 0);
    wait_ready(n);
    model_prog(2, 8'h5A, 0);
    start_op(0, 1, 0, 0, 1);
    wait_ready(n);
    model_erase(1);
    rd(2, v);
    check(v == model[2], "R2 locked boot byte kept", v, model[2]);
    rd(40, v);
    check(v == 8'hFF, "R2 main byte erased", v, 8'hFF);
    start_op(1, 0, 2, 8'h00, 1);
    wait_ready(n);
    model_prog(2, 8'h00, 1);
    rd(2, v);
    check(v == model[2], "R3 locked program ignored", v, model[2]);
    start_op(1, 0, 40, 8'h00, 1);
    wait_ready(n);
    model_prog(40, 8'h00, 1);
    rd(40, v);
    check(v == 8'h00, "R3 main program under lock", v, 0);

    // R10 tie: erase wins
    start_op(1, 1, 40, 8'h00, 0);
    wait_ready(n);
    check(n == ECYC, "R10 tie runs erase", n, ECYC);
    model_erase(0);
    check_all("R10 tie erased array");

    // R9 write enable blocks flag
    @(negedge clk);
    ce = 1; oe = 1; we = 1;
    @(negedge clk);
    check(oe_flag == 0, "R9 we blocks flag", oe_flag, 0);
    we = 0;
    @(negedge clk);
    check(oe_flag == 1, "R9 flag on read", oe_flag, 1);
    ce = 0; oe = 0;
    @(negedge clk);
    check(oe_flag == 0, "R9 flag drops", oe_flag, 0);

    // R7 abort mid-program
    start_op(1, 0, 10, 8'h00, 0);
    ce = 1; oe = 1; addr = 10;
    @(negedge clk);
    @(negedge clk);
    check(oe_flag == 1 && ry_by_n == 0, "R7 busy before abort", {oe_flag, ry_by_n}, 2'b10);
    rst_ni = 0;
    #1;
    check(oe_flag == 0 && ry_by_n == 1, "R7 abort clears", {oe_flag, ry_by_n}, 2'b01);
    @(negedge clk);
    rst_ni = 1; ce = 0; oe = 0;
    repeat (PCYC + 2) @(negedge clk);
    check(ry_by_n == 1, "R7 stays ready", ry_by_n, 1);
    rd(10, v);
    check(v == model[10], "R7 aborted byte unchanged", v, model[10]);

    summary();
  end
endmodule